// File: doc/BRIEF.md
# Serial Control Register Slave for an Audio Decoder

This block is a two-wire serial slave that holds the control settings of a broadcast-audio decoder. It samples the serial clock and data lines on the system clock through two-flop synchronisers. It detects start and stop conditions on the synchronised lines and answers one fixed 7-bit device address. The slave pulls the data line low to acknowledge each accepted byte. It drives the line only through an open-drain style pull output, so it never drives the line high.

A write frame carries the device address, then a sub-address byte, then any number of data bytes. The low nibble of the sub-address picks the first register. The high nibble picks the burst behaviour: the address either steps to the next register after each data byte, or stays put so that every byte rewrites the same register. Five sub-addresses hold storage, and their contents appear on parallel output ports. A read frame has no sub-address phase. The slave returns a status byte built from two live detector inputs, and it repeats that byte for as long as the master keeps acknowledging.

Top module: `i2c_ctrl_slave`

## Requirements
- R1: After reset, all five configuration outputs are 0x00, `agc_on_o` is 0 and `sda_pull_o` is 0.
- R2: An address byte whose upper seven bits equal 1011011 is acknowledged. This holds for a write (bit 0 = 0, byte 0xB6) and for a read (bit 0 = 1, byte 0xB7).
- R3: Any other address byte is not acknowledged. The slave then keeps `sda_pull_o` at 0 and stores nothing until the next start condition.
- R4: When the sub-address high nibble is any value other than 8, each data byte is stored at the current register index, and the index then steps up by one.
- R5: When the sub-address high nibble is 8, every data byte of the frame is stored at the same register index.
- R6: Only indices 0x0, 0x1, 0x2, 0x5 and 0x6 store data, onto `cfg00_o`, `cfg01_o`, `cfg02_o`, `cfg05_o` and `cfg06_o`. Bytes aimed at any other index are acknowledged and discarded. A stepping index wraps from 0xF to 0x0.
- R7: In a read, the slave sends a status byte MSB first, with bit 7 = `pilot_det_i` and bit 6 = `sap_det_i` sampled when the byte is loaded, and bits 5:0 = 0. After each master acknowledge it sends a fresh status byte. After a master not-acknowledge it releases the line until the next start condition. A read changes no register.
- R8: `agc_on_o` is 1 exactly when bits 7:6 of the register at index 0 are not 00.
- R9: Every byte of a write frame with a matching address is acknowledged during the ninth clock. The slave releases the line again after that clock falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND bus value) |
| pilot_det_i | input | 1 | Stereo pilot detector flag, 1 = detected |
| sap_det_i | input | 1 | Second-audio carrier detector flag, 1 = detected |
| sda_pull_o | output | 1 | 1 = slave pulls the data line low |
| cfg00_o | output | 8 | Register at index 0x0 (bits 7:6 AGC curve) |
| cfg01_o | output | 8 | Register at index 0x1 |
| cfg02_o | output | 8 | Register at index 0x2 |
| cfg05_o | output | 8 | Register at index 0x5 |
| cfg06_o | output | 8 | Register at index 0x6 |
| agc_on_o | output | 1 | AGC enabled flag decoded from index 0x0 |

## Verification
The assertions assume a well-behaved master. It holds each SCL level longer than the synchroniser and edge-detect delay, it changes SDA only while SCL is low, and it never issues a start or stop while the slave is pulling the line. Under that assumption the pull output may only change while the synchronised clock is low. The bench keeps every SCL phase six system clocks long. It changes its own SDA level only in the same step that SCL goes low or during the low phase, and it raises SCL only after the slave's response has settled. It forms the bus value as the AND of its own drive and the inverted pull output. It then compares a behavioural register model against the outputs on every clock while SCL is high.

// File: rtl/i2c_ctrl_slave.sv
module i2c_ctrl_slave #(
  parameter logic [6:0] DEV_ID = 7'b1011011
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       pilot_det_i,
  input  logic       sap_det_i,
  output logic       sda_pull_o,
  output logic [7:0] cfg00_o,
  output logic [7:0] cfg01_o,
  output logic [7:0] cfg02_o,
  output logic [7:0] cfg05_o,
  output logic [7:0] cfg06_o,
  output logic       agc_on_o
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_SUB, S_DATA, S_RD, S_IGN} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_p, sda_p;
  logic       scl_s, sda_s;
  logic       start_c, stop_c, rise, fall;

  st_t        st;
  logic [3:0] bitcnt;
  logic [7:0] shr, tx;
  logic       ack_q, drv_en, renew;
  logic [3:0] idx;
  logic [7:0] r00, r01, r02, r05, r06;
  logic       quiet, in_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_p  <= scl_sy[1];
      sda_p  <= sda_sy[1];
    end
  end

  assign scl_s   = scl_sy[1];
  assign sda_s   = sda_sy[1];
  assign start_c = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_c  = scl_s & scl_p & ~sda_p & sda_s;
  assign rise    = scl_s & ~scl_p;
  assign fall    = ~scl_s & scl_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      bitcnt <= '0;
      shr    <= '0;
      tx     <= '0;
      ack_q  <= 1'b0;
      drv_en <= 1'b0;
      renew  <= 1'b0;
      idx    <= '0;
      r00    <= '0;
      r01    <= '0;
      r02    <= '0;
      r05    <= '0;
      r06    <= '0;
    end else if (start_c) begin
      st     <= S_ADDR;
      bitcnt <= '0;
      ack_q  <= 1'b0;
      drv_en <= 1'b0;
    end else if (stop_c) begin
      st     <= S_IDLE;
      ack_q  <= 1'b0;
      drv_en <= 1'b0;
    end else if (fall && ack_q) begin
      ack_q  <= 1'b0;
      bitcnt <= '0;
      if (st == S_RD) begin
        drv_en <= 1'b1;
        tx     <= {pilot_det_i, sap_det_i, 6'b0};
      end
    end else if (!ack_q) begin
      case (st)
        S_ADDR, S_SUB, S_DATA: begin
          if (rise && bitcnt != 4'd8) begin
            shr    <= {shr[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (fall && bitcnt == 4'd8) begin
            case (st)
              S_ADDR: begin
                if (shr[7:1] == DEV_ID) begin
                  ack_q <= 1'b1;
                  st    <= shr[0] ? S_RD : S_SUB;
                end else begin
                  st <= S_IGN;
                end
              end
              S_SUB: begin
                ack_q <= 1'b1;
                idx   <= shr[3:0];
                renew <= (shr[7:4] == 4'h8);
                st    <= S_DATA;
              end
              default: begin
                ack_q <= 1'b1;
                case (idx)
                  4'h0: r00 <= shr;
                  4'h1: r01 <= shr;
                  4'h2: r02 <= shr;
                  4'h5: r05 <= shr;
                  4'h6: r06 <= shr;
                  default: ;
                endcase
                if (!renew) idx <= idx + 4'd1;
              end
            endcase
          end
        end
        S_RD: begin
          if (rise) begin
            if (bitcnt < 4'd8) bitcnt <= bitcnt + 4'd1;
            else if (bitcnt == 4'd8) begin
              if (sda_s) st <= S_IGN;
              else bitcnt <= 4'd9;
            end
          end else if (fall) begin
            if (bitcnt == 4'd8) drv_en <= 1'b0;
            else if (bitcnt == 4'd9) begin
              tx     <= {pilot_det_i, sap_det_i, 6'b0};
              bitcnt <= '0;
              drv_en <= 1'b1;
            end else if (bitcnt != 4'd0) tx <= {tx[6:0], 1'b0};
          end
        end
        default: ;
      endcase
    end
  end

  assign quiet      = (st == S_IDLE) || (st == S_IGN);
  assign in_rd      = (st == S_RD);
  assign sda_pull_o = ack_q | (in_rd & drv_en & ~tx[7]);
  assign cfg00_o    = r00;
  assign cfg01_o    = r01;
  assign cfg02_o    = r02;
  assign cfg05_o    = r05;
  assign cfg06_o    = r06;
  assign agc_on_o   = |r00[7:6];

endmodule

// File: rtl/i2c_ctrl_slave_chk.sv
module i2c_ctrl_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_s,
  input logic        quiet,
  input logic        in_rd,
  input logic        sda_pull,
  input logic [39:0] regs
);

  p_quiet_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> !sda_pull);

  p_pull_moves_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_s);

  p_one_reg_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({regs[39:32] != $past(regs[39:32]), regs[31:24] != $past(regs[31:24]),
              regs[23:16] != $past(regs[23:16]), regs[15:8] != $past(regs[15:8]),
              regs[7:0] != $past(regs[7:0])}));

  p_read_keeps_regs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_rd |=> $stable(regs));

endmodule

bind i2c_ctrl_slave i2c_ctrl_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_s),
  .quiet    (quiet),
  .in_rd    (in_rd),
  .sda_pull (sda_pull_o),
  .regs     ({cfg00_o, cfg01_o, cfg02_o, cfg05_o, cfg06_o})
);

// File: tb/i2c_ctrl_slave_bench.sv
module i2c_ctrl_slave_bench;
  localparam int Q = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, pilot = 1'b0, sap = 1'b0;
  logic sda_pull, agc_on;
  logic [7:0] c00, c01, c02, c05, c06;
  wire  sda_bus = m_sda & ~sda_pull;

  i2c_ctrl_slave u_i2c_ctrl_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .pilot_det_i(pilot), .sap_det_i(sap), .sda_pull_o(sda_pull),
    .cfg00_o(c00), .cfg01_o(c01), .cfg02_o(c02), .cfg05_o(c05), .cfg06_o(c06),
    .agc_on_o(agc_on)
  );

  int checks = 0, errors = 0;
  logic [7:0] mdl [16];
  bit cmp_en = 1'b0, hold = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  always @(negedge clk) begin
    if (cmp_en && !hold && m_scl) begin
      chk(c00 === mdl[0], "R6 cfg00", c00, mdl[0]);
      chk(c01 === mdl[1], "R6 cfg01", c01, mdl[1]);
      chk(c02 === mdl[2], "R6 cfg02", c02, mdl[2]);
      chk(c05 === mdl[5], "R6 cfg05", c05, mdl[5]);
      chk(c06 === mdl[6], "R6 cfg06", c06, mdl[6]);
      chk(agc_on === (mdl[0][7:6] != 2'b00), "R8 agc flag", agc_on, mdl[0][7:6] != 2'b00);
    end
  end

  task automatic bus_start();
    m_sda = 1'b1; wt(Q);
    m_scl = 1'b1; wt(Q);
    m_sda = 1'b0; wt(Q);
    m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(Q);
    m_scl = 1'b1; wt(Q);
    m_sda = 1'b1; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input bit chk_rel, input string tag);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wt(Q);
      m_scl = 1'b1; wt(Q);
      m_scl = 1'b0;
    end
    m_sda = 1'b1; wt(Q);
    chk(sda_pull === exp_ack, tag, sda_pull, exp_ack);
    m_scl = 1'b1; wt(Q);
    chk(sda_bus === !exp_ack, tag, sda_bus, !exp_ack);
    m_scl = 1'b0; wt(Q);
    if (chk_rel) chk(sda_pull === 1'b0, "R9 release after ninth clock", sda_pull, 0);
  endtask

  task automatic read_byte(output logic [7:0] v, input bit mack, input bit np, input bit ns);
    for (int i = 7; i >= 0; i--) begin
      m_scl = 1'b1; wt(Q);
      v[i] = sda_bus;
      m_scl = 1'b0; wt(Q);
    end
    pilot = np; sap = ns;
    m_sda = mack ? 1'b0 : 1'b1; wt(Q);
    m_scl = 1'b1; wt(Q);
    m_scl = 1'b0; m_sda = 1'b1; wt(Q);
  endtask

  task automatic write_frame(input logic [7:0] sub, input logic [7:0] d [$]);
    int  ix;
    bit  rn;
    hold = 1'b1;
    bus_start();
    send_byte(8'hB6, 1'b1, 1'b1, "R2 write address ack");
    send_byte(sub, 1'b1, 1'b1, "R9 sub-address ack");
    ix = int'(sub[3:0]);
    rn = (sub[7:4] == 4'h8);
    foreach (d[k]) begin
      send_byte(d[k], 1'b1, 1'b1, "R9 data ack");
      if (ix == 0 || ix == 1 || ix == 2 || ix == 5 || ix == 6) mdl[ix] = d[k];
      if (!rn) ix = (ix + 1) % 16;
    end
    bus_stop();
    hold = 1'b0;
    wt(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    wt(4);
    rst_n = 1'b1;
    wt(4);
    chk({c00, c01, c02, c05, c06} === 40'h0, "R1 registers after reset", {c00, c01}, 0);
    chk(sda_pull === 1'b0, "R1 pull after reset", sda_pull, 0);
    chk(agc_on === 1'b0, "R1 agc after reset", agc_on, 0);
    cmp_en = 1'b1;

    // R4 stepping burst from index 0, indices 3 and 4 discarded (R6)
    write_frame(8'h00, '{8'h40, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66});
    chk(c01 === 8'h11 && c02 === 8'h22, "R4 stepping burst", {c01, c02}, 16'h1122);
    chk(c05 === 8'h55 && c06 === 8'h66, "R4 stepping burst tail", {c05, c06}, 16'h5566);
    chk(agc_on === 1'b1, "R8 curve 01 enables", agc_on, 1);

    // R5 renewal into index 1
    write_frame(8'h81, '{8'hA1, 8'hA2, 8'hA3});
    chk(c01 === 8'hA3, "R5 renewal last byte", c01, 8'hA3);
    chk(c02 === 8'h22, "R5 neighbour untouched", c02, 8'h22);

    // R6 wrap from 0xF to 0x0
    write_frame(8'h0E, '{8'h77, 8'h88, 8'h99, 8'h5A});
    chk(c00 === 8'h99 && c01 === 8'h5A, "R6 wrap to index 0", {c00, c01}, 16'h995A);

    // R6 renewal onto an unimplemented index
    write_frame(8'h83, '{8'hFF, 8'hEE});
    chk({c00, c01, c02, c05, c06} === {8'h99, 8'h5A, 8'h22, 8'h55, 8'h66}, "R6 discard index 3",
        c00, 8'h99);

    // R3 address mismatch: no ack, nothing stored
    hold = 1'b1;
    bus_start();
    send_byte(8'hA6, 1'b0, 1'b0, "R3 no ack on mismatch");
    send_byte(8'h00, 1'b0, 1'b0, "R3 silent sub-address");
    send_byte(8'h12, 1'b0, 1'b0, "R3 silent data");
    bus_stop();
    hold = 1'b0;
    wt(2);
    chk(c00 === 8'h99, "R3 registers unchanged", c00, 8'h99);
    bus_start();
    send_byte(8'hA7, 1'b0, 1'b0, "R3 no ack on read mismatch");
    bus_stop();
    wt(2);

    // R8 curve 00 disables, curve 11 enables
    write_frame(8'h80, '{8'h3F});
    chk(agc_on === 1'b0, "R8 curve 00 disables", agc_on, 0);
    write_frame(8'h00, '{8'hC0});
    chk(agc_on === 1'b1, "R8 curve 11 enables", agc_on, 1);

    // R7 read: two bytes, detectors change between them
    pilot = 1'b1; sap = 1'b0;
    hold = 1'b1;
    bus_start();
    send_byte(8'hB7, 1'b1, 1'b0, "R2 read address ack");
    read_byte(v, 1'b1, 1'b1, 1'b1);
    chk(v === 8'h80, "R7 status pilot only", v, 8'h80);
    read_byte(v, 1'b0, 1'b0, 1'b1);
    chk(v === 8'hC0, "R7 status both flags", v, 8'hC0);
    for (int i = 0; i < 8; i++) begin
      m_scl = 1'b1; wt(Q);
      chk(sda_bus === 1'b1, "R7 released after nack", sda_bus, 1);
      m_scl = 1'b0; wt(Q);
    end
    bus_stop();
    hold = 1'b0;
    wt(2);
    chk(c00 === 8'hC0 && c01 === 8'h5A, "R7 read leaves registers", {c00, c01}, 16'hC05A);

    // R7 status with only the second-audio flag
    pilot = 1'b0; sap = 1'b1;
    bus_start();
    send_byte(8'hB7, 1'b1, 1'b0, "R2 read address ack");
    read_byte(v, 1'b0, 1'b0, 1'b1);
    chk(v === 8'h40, "R7 status second-audio only", v, 8'h40);
    bus_stop();
    wt(4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule